// File: doc/BRIEF.md
# Serial Bias-Level Control Core

This block is the digital control core of a boost bias supply. A host writes an 8-bit level code over a write-only three-wire serial port that has an active-low select, a serial clock and a data line. The block holds that code in a register that sets the converter's operating point. The all-zero code is not a level: it is a request to shut the converter down. An enable output follows the stored code and an external power-good signal. A discharge output is the inverse of that enable.

An asynchronous current-limit comparator input is retimed onto ticks of a divided switching oscillator. The active-low limit flag therefore moves only on those ticks. Every pin of the serial port, the comparator and power-good is brought into the system clock through a chain of synchronising stages. The system clock must run at least eight times faster than the serial clock.

Top module: `bias_ctrl_core`

## Requirements
- R1: Data is shifted in most-significant bit first, on rising serial-clock edges while select is low. When select rises after exactly 8 such edges, levelCode takes the shifted byte on the third system clock edge after the rising select level is first sampled.
- R2: After reset, levelCode is 8'hFF.
- R3: When levelCode is 8'h00, convEnable is low. A later valid write of a nonzero code raises convEnable again while powerGood is high.
- R4: Writes are accepted while the converter is shut down and while powerGood is low.
- R5: A transfer with any edge count other than 8 (0, 7 or 9 are tested) leaves levelCode unchanged.
- R6: limitFlagN is low when limitHit (through two sync stages) was high at the last oscillator tick, and high otherwise. It changes only on the clock edge that follows a cycle in which oscTick is high. After reset it is high.
- R7: convEnable is high exactly when levelCode is nonzero and powerGood, delayed by two sync stages, is high.
- R8: compDischarge is high whenever convEnable is low, and low otherwise.
- R9: oscTick is high for one clock in every OSC_DIV clocks. Its first pulse comes OSC_DIV-1 clocks after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| spiCsN | input | 1 | Serial select, active low |
| spiSclk | input | 1 | Serial clock, data taken on rising edge |
| spiDin | input | 1 | Serial data, MSB first |
| limitHit | input | 1 | Current-limit comparator, asynchronous |
| powerGood | input | 1 | Supply above undervoltage threshold, asynchronous |
| levelCode | output | 8 | Stored level code driving the converter setting |
| convEnable | output | 1 | Converter run enable |
| compDischarge | output | 1 | Compensation node discharge request |
| limitFlagN | output | 1 | Active-low limit flag, retimed to oscillator ticks |
| oscTick | output | 1 | One-clock pulse of the switching oscillator |

## Verification
A new level code appears three system clocks after the rising select is first sampled. An enable change from powerGood shows two clocks after the input moves. A limit flag change shows one clock after the first oscillator tick that follows two clocks of synchronisation. The bench models these delays with short histories of the sampled inputs. It compares every output at the falling clock edge on every cycle, so a result that is one cycle early or late is reported. Directed checks after each transfer wait more than this latency before sampling.

// File: rtl/bias_ctrl_pkg.sv
package bias_ctrl_pkg;
  // strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic shiftEn;  // take one serial bit
    logic commit;   // load shifted byte into level register
    logic oscTick;  // switching oscillator edge
  } ctlStrobe_t;
endpackage

// File: rtl/bias_ctrl_sync.sv
module bias_ctrl_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= RST_VAL;
        else       stage[g] <= asyncIn;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= RST_VAL;
        else       stage[g] <= stage[g-1];
      end
    end
  end

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/bias_ctrl_ctl.sv
module bias_ctrl_ctl
  import bias_ctrl_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter int OSC_DIV = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       spiCsN,
  input  logic       spiSclk,
  output ctlStrobe_t strobe
);
  localparam int CNT_W = $clog2(CODE_W + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CODE_W);
  localparam int OSC_W = (OSC_DIV > 2) ? $clog2(OSC_DIV) : 1;
  localparam logic [OSC_W-1:0] OSC_LAST = OSC_W'(OSC_DIV - 1);

  logic csSync, sclkSync;
  logic csPrev, sclkPrev;
  logic sclkRise, csFall, csRise;
  logic [CNT_W-1:0] bitCnt;
  logic [OSC_W-1:0] oscCnt;

  bias_ctrl_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) uPortSync (
    .clk(clk), .rstN(rstN),
    .asyncIn({spiCsN, spiSclk}),
    .syncOut({csSync, sclkSync})
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev   <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      csPrev   <= csSync;
      sclkPrev <= sclkSync;
    end
  end

  assign sclkRise = sclkSync & ~sclkPrev & ~csSync;
  assign csFall   = ~csSync & csPrev;
  assign csRise   = csSync & ~csPrev;

  // edge counter, saturates so long transfers never alias to a full byte
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              bitCnt <= '0;
    else if (csFall)                        bitCnt <= '0;
    else if (sclkRise && bitCnt != CNT_MAX) bitCnt <= bitCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 oscCnt <= '0;
    else if (oscCnt == OSC_LAST) oscCnt <= '0;
    else                       oscCnt <= oscCnt + 1'b1;
  end

  always_comb begin
    strobe.shiftEn = sclkRise;
    strobe.commit  = csRise && (bitCnt == CNT_FULL);
    strobe.oscTick = (oscCnt == OSC_LAST);
  end
endmodule

// File: rtl/bias_ctrl_dp.sv
module bias_ctrl_dp
  import bias_ctrl_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic              spiDin,
  input  logic              limitHit,
  input  logic              powerGood,
  output logic [CODE_W-1:0] levelCode,
  output logic              convEnable,
  output logic              compDischarge,
  output logic              limitFlagN
);
  localparam logic [CODE_W-1:0] RESET_CODE = '1;

  logic dinSync, limSync, pgSync;
  logic [CODE_W-1:0] shiftReg;

  bias_ctrl_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b000)) uDataSync (
    .clk(clk), .rstN(rstN),
    .asyncIn({spiDin, limitHit, powerGood}),
    .syncOut({dinSync, limSync, pgSync})
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               shiftReg <= '0;
    else if (strobe.shiftEn) shiftReg <= {shiftReg[CODE_W-2:0], dinSync};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              levelCode <= RESET_CODE;
    else if (strobe.commit) levelCode <= shiftReg;
  end

  // flag moves only with the switching oscillator to keep it quiet
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               limitFlagN <= 1'b1;
    else if (strobe.oscTick) limitFlagN <= ~limSync;
  end

  assign convEnable    = pgSync & (|levelCode);
  assign compDischarge = ~convEnable;
endmodule

// File: rtl/bias_ctrl_core.sv
module bias_ctrl_core #(
  parameter int CODE_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter int OSC_DIV = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiCsN,
  input  logic              spiSclk,
  input  logic              spiDin,
  input  logic              limitHit,
  input  logic              powerGood,
  output logic [CODE_W-1:0] levelCode,
  output logic              convEnable,
  output logic              compDischarge,
  output logic              limitFlagN,
  output logic              oscTick
);
  bias_ctrl_pkg::ctlStrobe_t strobe;

  bias_ctrl_ctl #(.CODE_W(CODE_W), .SYNC_STAGES(SYNC_STAGES), .OSC_DIV(OSC_DIV)) uCtl (
    .clk(clk), .rstN(rstN), .spiCsN(spiCsN), .spiSclk(spiSclk), .strobe(strobe)
  );

  bias_ctrl_dp #(.CODE_W(CODE_W), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .spiDin(spiDin),
    .limitHit(limitHit), .powerGood(powerGood), .levelCode(levelCode),
    .convEnable(convEnable), .compDischarge(compDischarge), .limitFlagN(limitFlagN)
  );

  assign oscTick = strobe.oscTick;
endmodule

// File: rtl/bias_ctrl_chk.sv
module bias_ctrl_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              spiCsN,
  input logic              powerGood,
  input logic [CODE_W-1:0] levelCode,
  input logic              convEnable,
  input logic              compDischarge,
  input logic              limitFlagN,
  input logic              oscTick
);
  AST_FLAG_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(limitFlagN) |-> $past(oscTick)); // R6

  AST_LEVEL_AFTER_DESELECT: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(levelCode) |-> ($past(spiCsN, 3) && !$past(spiCsN, 4))); // R5

  AST_ZERO_DISABLES: assert property (@(posedge clk) disable iff (!rstN)
    (levelCode == '0) |-> !convEnable); // R3

  AST_ENABLE_NEEDS_PG: assert property (@(posedge clk) disable iff (!rstN)
    convEnable |-> $past(powerGood, 2)); // R7

  AST_OFF_DISCHARGE: assert property (@(posedge clk) disable iff (!rstN)
    !convEnable |-> compDischarge); // R8

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    oscTick |=> !oscTick); // R9
endmodule

bind bias_ctrl_core bias_ctrl_chk #(.CODE_W(CODE_W)) uChk (
  .clk(clk), .rstN(rstN), .spiCsN(spiCsN), .powerGood(powerGood),
  .levelCode(levelCode), .convEnable(convEnable), .compDischarge(compDischarge),
  .limitFlagN(limitFlagN), .oscTick(oscTick)
);

// File: tb/bias_ctrl_core_test.sv
module bias_ctrl_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int OSC_DIV = 16;
  localparam int HALF = 8;  // serial half period in system clocks

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spiCsN = 1'b1, spiSclk = 1'b0, spiDin = 1'b0;
  logic limitHit = 1'b0, powerGood = 1'b0;
  logic [7:0] levelCode;
  logic convEnable, compDischarge, limitFlagN, oscTick;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  bias_ctrl_core #(.CODE_W(8), .SYNC_STAGES(2), .OSC_DIV(OSC_DIV)) uut (
    .clk(clk), .rstN(rstN), .spiCsN(spiCsN), .spiSclk(spiSclk), .spiDin(spiDin),
    .limitHit(limitHit), .powerGood(powerGood), .levelCode(levelCode),
    .convEnable(convEnable), .compDischarge(compDischarge),
    .limitFlagN(limitFlagN), .oscTick(oscTick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model: histories of sampled inputs, index 0 newest
  logic [3:0] hCs, hSck, hDin, hLim, hPg;
  int mCnt, mOsc;
  logic [7:0] mShift, mLevel;
  logic mFlag;

  always @(posedge clk) begin
    if (!rstN) begin
      hCs = '1; hSck = '0; hDin = '0; hLim = '0; hPg = '0;
      mCnt = 0; mOsc = 0; mShift = '0; mLevel = 8'hFF; mFlag = 1'b1;
    end else begin
      if (hCs[1] && !hCs[2] && mCnt == 8) mLevel = mShift;
      if (!hCs[1] && hCs[2]) mCnt = 0;
      else if (hSck[1] && !hSck[2] && !hCs[1] && mCnt < 15) mCnt++;
      if (hSck[1] && !hSck[2] && !hCs[1]) mShift = {mShift[6:0], hDin[1]};
      if (mOsc == OSC_DIV - 1) mFlag = !hLim[1];
      mOsc = (mOsc + 1) % OSC_DIV;
      hCs = {hCs[2:0], spiCsN};
      hSck = {hSck[2:0], spiSclk};
      hDin = {hDin[2:0], spiDin};
      hLim = {hLim[2:0], limitHit};
      hPg = {hPg[2:0], powerGood};
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  logic lastFlag = 1'b1;
  logic lastTick = 1'b0;
  always @(negedge clk) begin
    if (rstN && !finished) begin
      logic expEn;
      expEn = hPg[1] && (mLevel != 8'h00);
      chk("R1 levelCode", levelCode, mLevel);
      chk("R7 convEnable", convEnable, expEn);
      chk("R8 compDischarge", compDischarge, !expEn);
      chk("R6 limitFlagN", limitFlagN, mFlag);
      chk("R9 oscTick", oscTick, (mOsc == OSC_DIV - 1));
      if (limitFlagN != lastFlag) chk("R6 flag moved without tick", lastTick, 1);
      lastFlag = limitFlagN;
      lastTick = oscTick;
    end
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spiXfer(input logic [15:0] word, input int nbits);
    spiCsN = 1'b0;
    waitClk(HALF);
    for (int i = nbits - 1; i >= 0; i--) begin
      spiDin = word[i];
      spiSclk = 1'b0;
      waitClk(HALF);
      spiSclk = 1'b1;
      waitClk(HALF);
    end
    spiSclk = 1'b0;
    waitClk(HALF);
    spiCsN = 1'b1;
    waitClk(2 * HALF);
  endtask

  task automatic summary();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    waitClk(5);
    rstN = 1'b1;
    waitClk(4);
    chk("R2 reset code", levelCode, 8'hFF);
    chk("R7 no power-good", convEnable, 0);
    chk("R8 discharge at start", compDischarge, 1);
    chk("R6 flag idle high", limitFlagN, 1);
    powerGood = 1'b1;
    waitClk(4);
    chk("R7 enable with power-good", convEnable, 1);

    spiXfer(16'h00A5, 8);
    chk("R1 MSB first A5", levelCode, 8'hA5);
    spiXfer(16'h0000, 8);
    chk("R3 shutdown code", levelCode, 8'h00);
    chk("R3 shutdown disables", convEnable, 0);
    chk("R8 discharge in shutdown", compDischarge, 1);
    spiXfer(16'h003C, 8);
    chk("R4 write during shutdown", levelCode, 8'h3C);
    chk("R3 re-enable", convEnable, 1);

    spiXfer(16'h007F, 7);
    chk("R5 seven edges ignored", levelCode, 8'h3C);
    spiXfer(16'h0111, 9);
    chk("R5 nine edges ignored", levelCode, 8'h3C);
    spiXfer(16'h0000, 0);
    chk("R5 empty select ignored", levelCode, 8'h3C);

    powerGood = 1'b0;
    waitClk(4);
    chk("R7 power-good low disables", convEnable, 0);
    spiXfer(16'h0077, 8);
    chk("R4 write while power-good low", levelCode, 8'h77);
    chk("R7 still disabled", convEnable, 0);
    powerGood = 1'b1;
    waitClk(4);
    chk("R7 enable after power-good", convEnable, 1);

    limitHit = 1'b1;
    waitClk(3 * OSC_DIV);
    chk("R6 flag low in limit", limitFlagN, 0);
    limitHit = 1'b0;
    waitClk(3 * OSC_DIV);
    chk("R6 flag released", limitFlagN, 1);
    for (int k = 0; k < 6; k++) begin
      limitHit = ~limitHit;
      waitClk(5 + k);
    end
    limitHit = 1'b0;

    begin
      int ticks = 0;
      for (int k = 0; k < 4 * OSC_DIV; k++) begin
        waitClk(1);
        if (oscTick) ticks++;
      end
      chk("R9 tick rate", ticks, 4);
    end

    waitClk(3 * OSC_DIV);
    summary();
  end
endmodule